// File: doc/BRIEF.md
# Response Frame Transmit Sequencer

This block sequences the sending of short immediate-response frames, such as acknowledgements and clear-to-send replies. Software arms it with a one-cycle start strobe. The strobe carries a packet buffer index, an antenna mask and a flag that says whether the medium must be idle. The sequencer then waits for the interval timer that runs after a reception. When that timer reports expiry, the sequencer makes one decision in that same cycle: it either launches the transmission or gives up.

A launch is a one-cycle pulse to the PHY that carries the buffer index and antenna mask captured at start. The sequencer then waits for the PHY to report that transmission has ended, pulses `done`, and returns to idle. No post-transmit timeout window is opened.

When the idle flag is set and the medium is busy at the decision point, nothing is transmitted. Instead `done` and `aborted` pulse together. When the idle flag is clear, the frame goes out whatever the medium state. This suits acknowledgements, while clear-to-send uses the gated path.

Top module: `resp_tx_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `phy_tx_start`, `done` and `aborted` are low and the sequencer is idle.
- R2: After an accepted start, `phy_tx_start` stays low until `rx_timer_done` is sampled high. It then rises in the cycle right after that sampling edge.
- R3: `phy_tx_start` is high for exactly one cycle. During that cycle `phy_tx_buf` and `phy_tx_ant` equal the `buf_idx` and `ant_mask` sampled with the accepted start, whatever those inputs do later.
- R4: With `require_idle` low at start, the frame is launched when the timer expires even if `medium_idle` is low.
- R5: With `require_idle` high at start and `medium_idle` high in the timer-expiry cycle, the frame is launched.
- R6: With `require_idle` high at start and `medium_idle` low in the timer-expiry cycle, no launch happens. `done` and `aborted` are both high for one cycle, in the cycle right after expiry, and the sequencer returns to idle.
- R7: `phy_tx_done` sampled high while the sequencer awaits the PHY gives a one-cycle `done` with `aborted` low in the next cycle. The sequencer is idle again at once, so a start on the following cycle is accepted, and no further output activity follows.
- R8: A start strobe arriving while the sequencer is not idle has no effect. It neither changes the captured buffer and antenna values nor causes an extra launch.
- R9: `sw_reset` high returns the sequencer to idle from any state and takes priority over `start`. No launch and no `done` follow from the interrupted sequence.
- R10: `rx_timer_done` or `phy_tx_done` pulses that arrive while the sequencer is idle produce no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software abort to idle |
| start | input | 1 | One-cycle arm strobe |
| require_idle | input | 1 | Condition launch on idle medium |
| buf_idx | input | BUF_W | Packet buffer index, captured at start |
| ant_mask | input | ANT_W | Antenna mask, captured at start |
| rx_timer_done | input | 1 | Post-reception interval timer expired |
| medium_idle | input | 1 | Medium currently sensed idle |
| phy_tx_done | input | 1 | PHY finished transmitting |
| phy_tx_start | output | 1 | One-cycle launch pulse to PHY |
| phy_tx_buf | output | BUF_W | Captured buffer index |
| phy_tx_ant | output | ANT_W | Captured antenna mask |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | With `done`: frame was skipped |

## Verification
Four combinations of idle flag and medium state are tried. Clear flag with a busy medium separates ungated launch from gated launch. Set flag with idle and with busy media separates launch from abort. A timer that expires at once, compared with one that expires after a delay, shows that the launch is tied to the expiry edge and not to the start. Stray strobes are also applied: start while busy, software reset in each waiting state, and timer or PHY pulses while idle. Because the scoreboard expects no event for any of these, a missing guard shows up as an unexpected launch or completion. Changing `buf_idx` and `ant_mask` right after start shows whether they are captured.

// File: rtl/resp_tx_seq.sv
module resp_tx_seq #(
  parameter int BUF_W = 4,
  parameter int ANT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             start,
  input  logic             require_idle,
  input  logic [BUF_W-1:0] buf_idx,
  input  logic [ANT_W-1:0] ant_mask,
  input  logic             rx_timer_done,
  input  logic             medium_idle,
  input  logic             phy_tx_done,
  output logic             phy_tx_start,
  output logic [BUF_W-1:0] phy_tx_buf,
  output logic [ANT_W-1:0] phy_tx_ant,
  output logic             done,
  output logic             aborted
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT_TMR, S_WAIT_PHY} state_t;

  state_t st;
  logic   need_idle_q;
  logic   blocked;

  assign blocked = need_idle_q && !medium_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      need_idle_q  <= 1'b0;
      phy_tx_buf   <= '0;
      phy_tx_ant   <= '0;
      phy_tx_start <= 1'b0;
      done         <= 1'b0;
      aborted      <= 1'b0;
    end else begin
      phy_tx_start <= 1'b0;
      done         <= 1'b0;
      aborted      <= 1'b0;
      if (sw_reset) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            need_idle_q <= require_idle;
            phy_tx_buf  <= buf_idx;
            phy_tx_ant  <= ant_mask;
            st          <= S_WAIT_TMR;
          end
          S_WAIT_TMR: if (rx_timer_done) begin
            if (blocked) begin
              done    <= 1'b1;
              aborted <= 1'b1;
              st      <= S_IDLE;
            end else begin
              phy_tx_start <= 1'b1;
              st           <= S_WAIT_PHY;
            end
          end
          S_WAIT_PHY: if (phy_tx_done) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_tx_start |=> !phy_tx_start);

  // R2
  tx_after_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_tx_start |-> $past(rx_timer_done));

  // R6
  abort_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> done && $past(!medium_idle));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(phy_tx_buf) && $stable(phy_tx_ant));

  // R9
  swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> !phy_tx_start && !done);

endmodule

// File: tb/tb_resp_tx_seq.sv
module tb_resp_tx_seq;
  localparam int BW = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_reset = 0, start = 0, require_idle = 0;
  logic [BW-1:0] buf_idx = '0;
  logic [AW-1:0] ant_mask = '0;
  logic rx_timer_done = 0, medium_idle = 0, phy_tx_done = 0;
  logic phy_tx_start, done, aborted;
  logic [BW-1:0] phy_tx_buf;
  logic [AW-1:0] phy_tx_ant;

  always #4 clk = ~clk;

  resp_tx_seq #(.BUF_W(BW), .ANT_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .start(start),
    .require_idle(require_idle), .buf_idx(buf_idx), .ant_mask(ant_mask),
    .rx_timer_done(rx_timer_done), .medium_idle(medium_idle),
    .phy_tx_done(phy_tx_done), .phy_tx_start(phy_tx_start),
    .phy_tx_buf(phy_tx_buf), .phy_tx_ant(phy_tx_ant),
    .done(done), .aborted(aborted));

  typedef struct {
    int          kind;
    logic [BW-1:0] b;
    logic [AW-1:0] a;
    int          cyc;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always @(posedge clk) cyc++;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_ev(int kind, logic [BW-1:0] b, logic [AW-1:0] a, string req);
    item_t it;
    it.kind = kind; it.b = b; it.a = a; it.cyc = cyc + 1; it.req = req;
    q.push_back(it);
  endtask

  task automatic observe(int kind);
    item_t it;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event kind=%0d at cycle %0d (R8/R9/R10), expected none", kind, cyc);
    end else begin
      it = q.pop_front();
      if (it.kind != kind || it.cyc != cyc ||
          (kind == 0 && (phy_tx_buf != it.b || phy_tx_ant != it.a))) begin
        fails++;
        $display("FAIL %s: got kind=%0d cyc=%0d buf=%h ant=%h, expected kind=%0d cyc=%0d buf=%h ant=%h",
                 it.req, kind, cyc, phy_tx_buf, phy_tx_ant, it.kind, it.cyc, it.b, it.a);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (phy_tx_start) observe(0);
      if (done) observe(aborted ? 2 : 1);
      if (aborted && !done) begin
        checks++; fails++;
        $display("FAIL R6: aborted=1 done=0, expected done=1");
      end
    end
  end

  task automatic send(logic [BW-1:0] b, logic [AW-1:0] a, bit req, bit med,
                      int pre, int txc, string tag);
    tick();
    start = 1; buf_idx = b; ant_mask = a; require_idle = req;
    tick();
    start = 0; buf_idx = ~b; ant_mask = ~a; require_idle = ~req;
    for (int i = 0; i < pre; i++) tick();
    medium_idle = med; rx_timer_done = 1;
    if (req && !med) expect_ev(2, b, a, tag);
    else expect_ev(0, b, a, tag);
    tick();
    rx_timer_done = 0;
    if (!(req && !med)) begin
      for (int i = 0; i < txc; i++) tick();
      phy_tx_done = 1;
      expect_ev(1, b, a, "R7");
      tick();
      phy_tx_done = 0;
    end
  endtask

  initial begin
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog expired, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (phy_tx_start || done || aborted) begin
      fails++;
      $display("FAIL R1: start=%b done=%b aborted=%b, expected 000", phy_tx_start, done, aborted);
    end
    rst_n = 1;
    tick();

    send(4'h3, 4'h1, 0, 0, 3, 4, "R4");
    send(4'h5, 4'h2, 1, 1, 2, 3, "R5");
    send(4'h9, 4'h4, 1, 0, 2, 0, "R6");
    send(4'hA, 4'h8, 0, 1, 0, 1, "R2");
    send(4'hC, 4'h3, 0, 0, 6, 2, "R3");

    // R8: start while awaiting the PHY is ignored
    tick();
    start = 1; buf_idx = 4'h6; ant_mask = 4'h5; require_idle = 0;
    tick();
    start = 0;
    tick();
    rx_timer_done = 1; medium_idle = 1;
    expect_ev(0, 4'h6, 4'h5, "R8");
    tick();
    rx_timer_done = 0;
    start = 1; buf_idx = 4'hF; ant_mask = 4'hF;
    tick();
    start = 0;
    tick();
    checks++;
    if (phy_tx_buf != 4'h6 || phy_tx_ant != 4'h5) begin
      fails++;
      $display("FAIL R8: buf=%h ant=%h, expected 6 5", phy_tx_buf, phy_tx_ant);
    end
    phy_tx_done = 1;
    expect_ev(1, 0, 0, "R7");
    tick();
    phy_tx_done = 0;
    // R10: stray pulses while idle
    repeat (2) tick();
    rx_timer_done = 1;
    tick();
    rx_timer_done = 0; phy_tx_done = 1;
    tick();
    phy_tx_done = 0;
    repeat (4) tick();

    // R9: software reset while waiting for the timer
    start = 1; buf_idx = 4'h7; ant_mask = 4'h7;
    tick();
    start = 0;
    repeat (2) tick();
    sw_reset = 1;
    tick();
    sw_reset = 0;
    rx_timer_done = 1;
    tick();
    rx_timer_done = 0;
    repeat (3) tick();

    // R9: software reset while awaiting the PHY, with start in the same cycle
    start = 1; buf_idx = 4'h2; ant_mask = 4'h9;
    tick();
    start = 0;
    rx_timer_done = 1; medium_idle = 0;
    expect_ev(0, 4'h2, 4'h9, "R9");
    tick();
    rx_timer_done = 0;
    sw_reset = 1; start = 1;
    tick();
    sw_reset = 0; start = 0;
    phy_tx_done = 1;
    tick();
    phy_tx_done = 0;
    rx_timer_done = 1;
    tick();
    rx_timer_done = 0;
    repeat (3) tick();

    send(4'hE, 4'h6, 1, 1, 1, 2, "R7");
    send(4'h1, 4'hA, 1, 0, 0, 0, "R6");
    repeat (5) tick();

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2/R7: %0d expected events never seen, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule